// File: doc/BRIEF.md
# Sample-Rate Paced Audio Sample Player

The player streams a buffer of 16-bit PCM samples from memory to a DAC write port, one write per sample period. Software first writes two configuration values: the word address of the first sample and a phase step. The step is the sample rate scaled to the fabric clock, `step = rate * 2^32 / f_clk`. For a 40 MHz clock and rates from 8 kHz to 44.1 kHz, the step lies between about 859k and 4.74M. Software then pulses `start`.

A 32-bit phase accumulator adds the step on every clock while playback runs, and each carry out produces a one-cycle pacing tick. Because the accumulator carries the fractional remainder forward, rates that do not divide the clock show no long-term drift.

One sample is always fetched ahead of the next tick with a single word read from memory, and it is held until the tick arrives. A read that completes anywhere inside the sample period therefore never moves a DAC write. After the last sample of the buffer has been written, a done flag rises and stays high until the next playback is started.

Top module: `pcm_pace_player`

## Requirements
- R1: After synchronous reset, `dac_we`, `dac_data`, `mem_req` and `done` are all 0.
- R2: `cfg_we` with `cfg_sel`=0 loads the base word address from the low `ADDR_W` bits of `cfg_wdata`. With `cfg_sel`=1 it loads the 32-bit phase step. Both values are captured at an accepted start, so writes made during playback take effect only at the next start.
- R3: Number the clock edges from the edge that accepts start as edge 0. DAC write j (counting from 1) appears on the ports right after edge c_j+1, where c_j is the smallest integer with c_j*step >= j*2^32.
- R4: Every DAC write is a single-cycle `dac_we` pulse. Write j carries the word read at address (base + j - 1) mod 2^ADDR_W.
- R5: `mem_req` is a one-cycle pulse, and at most one read is outstanding at a time. A playback issues exactly `BUF_LEN` reads (default 4096), and no read is issued while idle.
- R6: The next sample is requested as soon as the previous one is handed to the DAC. A read latency shorter than the gap between ticks therefore never shifts any write away from the time given in R3.
- R7: `done` rises at the same clock edge as write number `BUF_LEN`. It stays high, with no further reads or writes, until the next accepted start, which clears it.
- R8: A `start` pulse during playback is ignored: the write sequence and its timing continue unchanged.
- R9: The span from the first to the last write of a playback equals (BUF_LEN-1)*2^32/step clock cycles to within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects base address, 1 selects phase step |
| cfg_wdata | input | ACC_W | Configuration write data |
| start | input | 1 | Start pulse, honoured only while idle |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | SMP_W | Read data (one sample per word) |
| dac_we | output | 1 | One-cycle DAC write strobe |
| dac_data | output | SMP_W | Sample written to the DAC |
| done | output | 1 | Whole buffer played |

## Verification
The assertions take it as given that the memory returns `mem_rvalid` only for a read that is outstanding. They also take it as given that every read completes before the next pacing tick, so a sample is always held when a tick arrives. The stimulus keeps within both conditions: its memory model answers each request exactly once, after 1 to 3 cycles. The phase steps it programs give at least seven cycles between ticks, so even the slowest read finishes with margin before the next tick.

// File: rtl/pcm_player_pkg.sv
`timescale 1ns/1ps
package pcm_player_pkg;
  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_STEP = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/rate_strobe_gen.sv
`timescale 1ns/1ps
module rate_strobe_gen #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [ACC_W-1:0] step,
  output logic             tick
);
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, phase_q} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase_q <= '0;
      tick    <= 1'b0;
    end else if (run) begin
      phase_q <= sum[ACC_W-1:0];
      tick    <= sum[ACC_W];
    end else begin
      tick    <= 1'b0;
    end
  end

  // Ticks only ever follow an edge on which the accumulator was advancing.
  assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !$past(clear)) |-> $past(run));
endmodule

// File: rtl/sample_fetch.sv
`timescale 1ns/1ps
module sample_fetch #(
  parameter int ADDR_W  = 20,
  parameter int SMP_W   = 16,
  parameter int BUF_LEN = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              active,
  input  logic              take,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [SMP_W-1:0]  mem_rdata,
  output logic              held,
  output logic [SMP_W-1:0]  sample
);
  localparam int CNT_W = $clog2(BUF_LEN + 1);

  logic [ADDR_W-1:0] next_addr;
  logic [CNT_W-1:0]  issued;
  logic              pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_addr <= '0;
      issued    <= '0;
      pending   <= 1'b0;
      held      <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      sample    <= '0;
    end else if (load) begin
      next_addr <= base;
      issued    <= '0;
      pending   <= 1'b0;
      held      <= 1'b0;
      mem_req   <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      if (take) held <= 1'b0;
      if (active && !held && !pending && issued < CNT_W'(BUF_LEN)) begin
        mem_req   <= 1'b1;
        mem_addr  <= next_addr;
        next_addr <= next_addr + 1'b1;
        issued    <= issued + 1'b1;
        pending   <= 1'b1;
      end
      if (pending && mem_rvalid) begin
        pending <= 1'b0;
        held    <= 1'b1;
        sample  <= mem_rdata;
      end
    end
  end

  assert_req_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (rst)
    (pending && !mem_rvalid && !load) |=> !mem_req);
  // Input assumption: the memory answers only an outstanding read.
  assert_resp_expected_R5: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> pending);
endmodule

// File: rtl/pcm_pace_player.sv
`timescale 1ns/1ps
module pcm_pace_player
  import pcm_player_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int SMP_W   = 16,
  parameter int BUF_LEN = 4096,
  parameter int ACC_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ACC_W-1:0]  cfg_wdata,
  input  logic              start,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [SMP_W-1:0]  mem_rdata,
  output logic              dac_we,
  output logic [SMP_W-1:0]  dac_data,
  output logic              done
);
  localparam int CNT_W = $clog2(BUF_LEN + 1);

  logic [ADDR_W-1:0] base_q;
  logic [ACC_W-1:0]  step_q;
  logic [ACC_W-1:0]  step_act;
  logic              running;
  logic [CNT_W-1:0]  wr_cnt;
  logic              tick;
  logic              held;
  logic [SMP_W-1:0]  held_smp;
  logic              start_ok;
  logic              take;

  assign start_ok = start && !running;
  assign take     = running && tick && held;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      step_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel_e'(cfg_sel) == SEL_BASE) base_q <= cfg_wdata[ADDR_W-1:0];
      else                                 step_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      step_act <= '0;
      wr_cnt   <= '0;
      dac_we   <= 1'b0;
      dac_data <= '0;
      done     <= 1'b0;
    end else begin
      dac_we <= 1'b0;
      if (start_ok) begin
        running  <= 1'b1;
        step_act <= step_q;
        wr_cnt   <= '0;
        done     <= 1'b0;
      end else if (take) begin
        dac_we   <= 1'b1;
        dac_data <= held_smp;
        wr_cnt   <= wr_cnt + 1'b1;
        if (wr_cnt == CNT_W'(BUF_LEN - 1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  rate_strobe_gen #(.ACC_W(ACC_W)) strobe_i (
    .clk  (clk),
    .rst  (rst),
    .clear(start_ok),
    .run  (running),
    .step (step_act),
    .tick (tick)
  );

  sample_fetch #(.ADDR_W(ADDR_W), .SMP_W(SMP_W), .BUF_LEN(BUF_LEN)) fetch_i (
    .clk       (clk),
    .rst       (rst),
    .load      (start_ok),
    .base      (base_q),
    .active    (running),
    .take      (take),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata),
    .held      (held),
    .sample    (held_smp)
  );

  // Input assumption: each read completes within one tick period.
  assert_ready_at_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (running && tick) |-> held);
  assert_dac_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    dac_we |=> !dac_we);
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> (!dac_we && !mem_req));
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    running |-> (wr_cnt < CNT_W'(BUF_LEN)));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (running && start && !done) |=> !done || $past(take));
endmodule

// File: tb/pcm_pace_player_tb_top.sv
`timescale 1ns/1ps
module pcm_pace_player_tb_top;
  localparam int AW  = 20;
  localparam int SW  = 16;
  localparam int LEN = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          start = 1'b0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [SW-1:0] mem_rdata = '0;
  logic          dac_we;
  logic [SW-1:0] dac_data;
  logic          done;

  int vecs = 0;
  int errs = 0;
  int req_count = 0;
  int idle_reqs = 0;
  bit playing = 1'b0;
  int mcnt = 0;
  int lat_sel = 0;
  logic [AW-1:0] maddr = '0;

  always #2.5 clk = ~clk;

  pcm_pace_player #(.ADDR_W(AW), .SMP_W(SW), .BUF_LEN(LEN), .ACC_W(32)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .start(start), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .dac_we(dac_we), .dac_data(dac_data), .done(done));

  function automatic logic [SW-1:0] memw(input logic [AW-1:0] a);
    logic [31:0] t;
    t = {12'd0, a} * 32'd40503;
    return t[15:0] ^ 16'h1d2b;
  endfunction

  // Memory model: latency of 1, 2 or 3 cycles, rotating.
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (mem_req === 1'b1) begin
      req_count++;
      if (!playing) idle_reqs++;
      maddr = mem_addr;
      mcnt = 1 + (lat_sel % 3);
      lat_sel++;
    end
    if (mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = memw(maddr);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One playback compared cycle by cycle against a behavioural model.
  task automatic play(input logic [AW-1:0] base, input bit wr_step, input longint step,
                      input bit disturb, input longint new_step);
    longint unsigned k;
    int wcount = 0, first_e = -1, last_e = -1, extra = 0, n = 0;
    bit exp_we, exp_done;
    real span;
    cfg_write(1'b0, 32'(base));
    if (wr_step) cfg_write(1'b1, step[31:0]);
    @(negedge clk);
    start = 1'b1;
    req_count = 0;
    playing = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R7 done cleared by start", done, 0);
    while (extra < 6 && n < 20000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      k = longint'(n) - 1;
      exp_we = (k >= 1) && (wcount < LEN) &&
               (((k * step) >> 32) != (((k - 1) * step) >> 32));
      chk(dac_we == exp_we, "R3,R6 write timing", dac_we, exp_we);
      if (exp_we) begin
        chk(dac_data == memw(base + AW'(wcount)), "R4 sample order",
            dac_data, memw(base + AW'(wcount)));
        if (first_e < 0) first_e = n;
        last_e = n;
        wcount++;
      end
      exp_done = (wcount == LEN);
      chk(done == exp_done, "R7 done flag", done, exp_done);
      if (exp_done) begin
        extra++;
        playing = 1'b0;
      end
      if (disturb && n == 20) start = 1'b1;    // R8: start while playing
      if (disturb && n == 21) start = 1'b0;
      if (disturb && n == 25) begin            // R2: mid-play step write
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = new_step[31:0];
      end
      if (disturb && n == 26) cfg_we = 1'b0;
    end
    chk(req_count == LEN, "R5 reads per playback", req_count, LEN);
    span = real'(LEN - 1) * 4294967296.0 / real'(step);
    chk((real'(last_e - first_e) - span) <= 1.0 && (span - real'(last_e - first_e)) <= 1.0,
        "R9 average spacing", last_e - first_e, longint'(span));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dac_we == 0, "R1 reset dac_we", dac_we, 0);
    chk(dac_data == 0, "R1 reset dac_data", dac_data, 0);
    chk(mem_req == 0, "R1 reset mem_req", mem_req, 0);
    chk(done == 0, "R1 reset done", done, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(idle_reqs == 0, "R5 no read while idle", idle_reqs, 0);
    // Step near clk/10, with a start pulse and a step write during play.
    play(20'h00100, 1'b1, 64'd429496730, 1'b1, 64'd268435456);
    // Only the base is rewritten: the step written mid-play applies now (R2).
    play(20'hFFFE0, 1'b0, 64'd268435456, 1'b0, 64'd0);
    // Fractional rate, near clk/7.3.
    play(20'h00003, 1'b1, 64'd588350000, 1'b0, 64'd0);
    repeat (10) @(negedge clk);
    chk(idle_reqs == 0, "R5 no read while idle", idle_reqs, 0);
    chk(done == 1'b1, "R7 done holds", done, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule